// File: doc/BRIEF.md
# Oversampled Serial Receive Channel

This block receives asynchronous serial frames: one start bit, eight data bits sent least significant bit first, and one stop bit. It samples its line input only on clock cycles where a shared tick enable is high, and one bit lasts eight ticks. Several channels can run side by side from one free-running 4-bit phase count, which is supplied from outside and advances by one after every tick.

Each channel holds two 4-bit fields. The slot field counts bit positions and is zero while the channel is idle. The target field holds the phase value at which the next sample falls due. When the line is seen low on a tick while the channel is idle, the target is set twelve ticks ahead, which is the middle of the first data bit. After each sample the target moves on by eight. Once the stop position has been sampled, the slot field wraps to zero, which returns the channel to idle, and a sticky ready flag is raised. The host reads the byte and then clears the flag.

Top module: `oversamp_rx`

## Requirements
- R1: After reset, `full` is 0, `data_out` is 0 and the channel is idle.
- R2: A low synchronised line seen on a tick while idle starts a frame. A line that stays high never raises `full`.
- R3: Samples fall on the ticks where `phase` equals the stored target. The first sample comes 12 ticks after the start detection and each later sample 8 ticks after the one before it, for nine samples in all.
- R4: The first eight samples are shifted in at bit 7 of `data_out`, so the first bit received ends up in bit 0.
- R5: The ninth sample, in the stop position, is not stored. A low stop bit still completes the frame with the data intact.
- R6: `full` goes to 1 on the clock edge of the stop sample and stays at 1 until `clr_full` is high on a clock edge. If a completion and a clear fall on the same edge, the completion wins.
- R7: While `tick` is low the receiver state does not change. Frames are received correctly at any tick rate.
- R8: `rx_in` passes through a two-flop synchroniser. With `tick` high on every cycle, a start edge driven just before clock edge k is detected at edge k+2, and `full` rises at edge k+78.
- R9: Reception is correct whatever value `phase` holds at the start edge, including targets that wrap past 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Sample enable, eight per bit time |
| phase | input | 4 | Shared phase count, advances by one after each tick |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| clr_full | input | 1 | Host clear of the ready flag |
| data_out | output | 8 | Received byte |
| full | output | 1 | Byte ready, sticky until cleared |

## Verification
The assertions take for granted that `phase` moves only in step with `tick`, and that `clr_full` is used only to clear the flag. If the phase count stood still or jumped, a due sample could be missed and the channel would stay busy for sixteen extra ticks. The bench drives `tick` and `phase` from a single generator that steps the phase once after each tick. It stops both together when it tests the frozen state, and it drives every input half a cycle away from the sampling edge.

// File: rtl/oversamp_rx.sv
module oversamp_rx #(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [3:0]           phase,
  input  logic                 rx_in,
  input  logic                 clr_full,
  output logic [DATA_BITS-1:0] data_out,
  output logic                 full
);
  localparam logic [3:0] SLOT_INIT = 4'(15 - DATA_BITS);
  localparam logic [3:0] FIRST_GAP = 4'd12;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [3:0] slot, target;

  wire line  = sync_q[SYNC_STAGES-1];
  wire idle  = (slot == 4'd0);
  wire start = tick && idle && !line;
  wire due   = tick && !idle && (target == phase);
  wire last  = (slot == 4'hF);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      slot     <= '0;
      target   <= '0;
      data_out <= '0;
    end else if (start) begin
      slot   <= SLOT_INIT;
      target <= phase + FIRST_GAP;
    end else if (due) begin
      slot   <= slot + 4'd1;
      target <= {~target[3], target[2:0]};
      if (!last) data_out <= {line, data_out[DATA_BITS-1:1]};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            full <= 1'b0;
    else if (due && last)  full <= 1'b1;
    else if (clr_full)     full <= 1'b0;
endmodule

module oversamp_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 clr_full,
  input logic                 full,
  input logic [3:0]           slot,
  input logic [3:0]           target,
  input logic [DATA_BITS-1:0] data_out
);
  localparam logic [3:0] SLOT_INIT = 4'(15 - DATA_BITS);

  assert_full_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> ($past(slot) == 4'hF && slot == 4'd0));

  assert_full_drop_needs_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(clr_full));

  assert_frozen_without_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(slot) && $stable(target) && $stable(data_out)));

  assert_idle_keeps_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == 4'd0) |=> $stable(data_out));

  assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == 4'd0) || (slot >= SLOT_INIT));

  assert_stop_not_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == 4'hF) |=> $stable(data_out));
endmodule

bind oversamp_rx oversamp_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .clr_full(clr_full), .full(full),
  .slot(slot), .target(target), .data_out(data_out)
);

// File: tb/tb_oversamp_rx.sv
module tb_oversamp_rx;
  logic clk = 0, rst_n = 0, tick = 0, rx_in = 1, clr_full = 0;
  logic [3:0] phase = 0;
  logic [7:0] data_out;
  logic full;
  int tdiv = 1, tcnt = 0, runs = 0, fails = 0;
  bit hold = 0;

  oversamp_rx dut (.clk(clk), .rst_n(rst_n), .tick(tick), .phase(phase), .rx_in(rx_in),
                   .clr_full(clr_full), .data_out(data_out), .full(full));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tick) phase <= phase + 4'd1;
    if (hold) begin tick <= 0; tcnt <= 0; end
    else if (tcnt + 1 >= tdiv) begin tcnt <= 0; tick <= 1; end
    else begin tcnt <= tcnt + 1; tick <= 0; end
  end

  initial begin
    #4_000_000;
    fails++; runs++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; rx_in = 1; clr_full = 0; hold = 0;
    step(3);
    rst_n = 1;
    step(2);
  endtask

  task automatic send(logic [7:0] b, logic stop_bit);
    rx_in = 0; step(8 * tdiv);
    for (int i = 0; i < 8; i++) begin rx_in = b[i]; step(8 * tdiv); end
    rx_in = stop_bit; step(8 * tdiv);
    rx_in = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 full", full, 0);
    chk("R1 data", data_out, 0);
  endtask

  task automatic t_idle();
    rx_in = 1; step(300);
    chk("R2 idle line", full, 0);
  endtask

  task automatic t_frame(logic [7:0] b, int div, logic [3:0] ph);
    do_reset();
    tdiv = div;
    do step(); while (phase != ph);
    send(b, 1);
    step(2);
    chk("R4/R9 data", data_out, b);
    chk("R7/R9 full", full, 1);
    tdiv = 1;
  endtask

  task automatic t_stop_low();
    do_reset();
    send(8'h6B, 0);
    step(1);
    chk("R5 data on low stop", data_out, 8'h6B);
    chk("R5 full on low stop", full, 1);
  endtask

  task automatic t_exact();
    logic [7:0] b = 8'hC4;
    logic [9:0] fr = {1'b1, b, 1'b0};
    do_reset();
    tdiv = 1; step(4);
    for (int i = 0; i < 90; i++) begin
      rx_in = fr[i / 8 > 9 ? 9 : i / 8];
      if (i == 78) begin
        chk("R8 full not yet", full, 0);
        chk("R3 data before stop", data_out, b);
        clr_full = 1;
      end
      if (i == 79) begin
        chk("R6 set wins over clear", full, 1);
        clr_full = 0;
      end
      step();
    end
    chk("R3 data kept", data_out, b);
  endtask

  task automatic t_clear();
    do_reset();
    send(8'h5A, 1);
    step(40);
    chk("R6 sticky", full, 1);
    clr_full = 1; step(); clr_full = 0;
    chk("R6 cleared", full, 0);
    chk("R6 data kept", data_out, 8'h5A);
  endtask

  task automatic t_freeze();
    logic [7:0] d0;
    do_reset();
    send(8'h81, 1);
    step(4);
    rx_in = 0; step(30);
    hold = 1; step(2);
    d0 = data_out;
    for (int i = 0; i < 100; i++) begin rx_in = i[1]; step(); end
    chk("R7 data frozen", data_out, d0);
    chk("R7 full frozen", full, 1);
    hold = 0;
  endtask

  initial begin
    t_reset();
    t_idle();
    t_frame(8'hA5, 1, 4'd0);
    t_frame(8'h3C, 1, 4'd7);
    t_frame(8'h00, 2, 4'd13);
    t_frame(8'hFF, 3, 4'd9);
    t_frame(8'h01, 1, 4'd15);
    t_stop_low();
    t_exact();
    t_clear();
    t_freeze();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule